// File: doc/BRIEF.md
# Dual-Bank Ping-Pong Buffer Controller

This block sits between two hosts and a pair of external byte-wide SRAM banks. One host only writes and the other only reads. At any moment the writer is attached to one bank and the reader to the other, so filling and draining run side by side. Neither host ever presents an address. Each bank keeps its own address counter, and the host attached to that bank moves it with three strobes: clear, step up and step down.

The controller drives the chip-select, write-enable and output-enable pins of each bank. It also drives one enable per host per bank for external bus transceivers, so a data bus is only joined to the host that owns the bank. A swap request exchanges the two banks between the hosts. The swap is taken only when both hosts are idle, and it passes through a break-before-make gap during which every transceiver is released.

Top module: `pp_buffer_ctrl`

## Requirements
- R1: A clear strobe from the owning host sets that bank's address to zero, step up adds one and step down subtracts one. The new address is on `bank_addr` one clock after the strobe. Bank b's address occupies bits `[b*ADDR_W +: ADDR_W]`.
- R2: When several strobes from one host arrive in the same cycle, clear wins over step up, and step up wins over step down.
- R3: Addresses wrap modulo 2^ADDR_W. Stepping up from the top address gives zero, and stepping down from zero gives the top address.
- R4: Each bank's counter moves only on strobes from the host currently attached to it. Strobes from the other host leave it unchanged.
- R5: While linked, the writer owns bank `wr_bank` and the reader owns the other bank. `wr_bank` reports which bank the writer holds (0 or 1).
- R6: `wr_xcvr_en[b]` is high only while the writer owns bank b, and `rd_xcvr_en[b]` is high only while the reader owns bank b. The two are never both high for one bank.
- R7: A swap request is taken only in a linked cycle where both `wr_req` and `rd_req` are low. While either is high, the request has no effect.
- R8: After a swap is taken, all transceiver enables stay low for GAP_CYCLES clocks before the new pairing is enabled. During the gap, strobes and access requests are ignored.
- R9: `bank_we_n[b]` is low only when the writer owns bank b and `wr_req` is high. `bank_oe_n[b]` is low only when the reader owns bank b and `rd_req` is high. `bank_cs_n[b]` is low exactly when one of them is low. Write-enable and output-enable are never both low on one bank.
- R10: After reset, both addresses are zero, `wr_bank` is 0 and the banks are linked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_clr | input | 1 | Writer: clear its bank's address |
| wr_inc | input | 1 | Writer: step its bank's address up |
| wr_dec | input | 1 | Writer: step its bank's address down |
| wr_req | input | 1 | Writer performs a write this cycle |
| rd_clr | input | 1 | Reader: clear its bank's address |
| rd_inc | input | 1 | Reader: step its bank's address up |
| rd_dec | input | 1 | Reader: step its bank's address down |
| rd_req | input | 1 | Reader performs a read this cycle |
| swap_req | input | 1 | Request to exchange the bank assignment |
| bank_addr | output | 2*ADDR_W | Address of both banks, bank b at [b*ADDR_W +: ADDR_W] |
| bank_cs_n | output | 2 | Chip select per bank, active low |
| bank_we_n | output | 2 | Write enable per bank, active low |
| bank_oe_n | output | 2 | Output enable per bank, active low |
| wr_xcvr_en | output | 2 | Writer bus transceiver enable per bank |
| rd_xcvr_en | output | 2 | Reader bus transceiver enable per bank |
| wr_bank | output | 1 | Bank currently held by the writer |

## Verification
The bench builds the block with ADDR_W set to 4 and GAP_CYCLES left at 1. The narrow counter lets sixteen step-up strobes and a single step-down strobe from zero exercise both wrap edges within a short run. The single-cycle gap lets a swap, the ignored strobes during the gap and the first access after the gap all fall inside a few table rows.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;

   localparam int NBANK = 2;

   typedef enum logic [1:0] {
      CMD_HOLD = 2'd0,
      CMD_CLR  = 2'd1,
      CMD_INC  = 2'd2,
      CMD_DEC  = 2'd3
   } ctr_cmd_e;

   // Resolve simultaneous strobes: clear, then step up, then step down.
   function automatic ctr_cmd_e pick_cmd(input logic c, input logic i, input logic d);
      if (c)      return CMD_CLR;
      else if (i) return CMD_INC;
      else if (d) return CMD_DEC;
      else        return CMD_HOLD;
   endfunction

endpackage

// File: rtl/pp_addr_ctr.sv
module pp_addr_ctr
   import pp_buf_pkg::*;
#(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctr_cmd_e          cmd,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   generate
      if (ADDR_W < 1) begin : g_bad_w
         $error("pp_addr_ctr: ADDR_W must be at least 1");
      end
   endgenerate

   // Modular arithmetic wraps at both ends without extra logic.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else begin
         case (cmd)
            CMD_CLR: addr <= '0;
            CMD_INC: addr <= addr + ONE;
            CMD_DEC: addr <= addr - ONE;
            default: addr <= addr;
         endcase
      end
   end

endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl #(
   parameter int GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic swap_req,
   input  logic busy,
   output logic wsel,
   output logic linked
);

   logic accept;

   generate
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("pp_swap_ctrl: GAP_CYCLES must be at least 1");
      end
   endgenerate

   assign accept = linked && swap_req && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wsel <= 1'b0;
      else if (accept) wsel <= ~wsel;
   end

   generate
      if (GAP_CYCLES == 1) begin : g_gap_one
         logic in_gap;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) in_gap <= 1'b0;
            else        in_gap <= accept;
         end
         assign linked = !in_gap;
      end else begin : g_gap_cnt
         localparam int GW = $clog2(GAP_CYCLES + 1);
         localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYCLES);
         logic [GW-1:0] gap_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              gap_cnt <= '0;
            else if (accept)         gap_cnt <= GAP_LOAD;
            else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
         end
         assign linked = (gap_cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/pp_bank_port.sv
module pp_bank_port
   import pp_buf_pkg::*;
#(
   parameter int BANK = 0
) (
   input  logic     wsel,
   input  logic     linked,
   input  ctr_cmd_e wr_cmd,
   input  ctr_cmd_e rd_cmd,
   input  logic     wr_req,
   input  logic     rd_req,
   output ctr_cmd_e ctr_cmd,
   output logic     wr_en,
   output logic     rd_en,
   output logic     we_n,
   output logic     oe_n,
   output logic     cs_n
);

   localparam logic MY_SEL = BANK[0];

   logic writer_owns;
   logic reader_owns;

   generate
      if (BANK < 0 || BANK >= NBANK) begin : g_bad_bank
         $error("pp_bank_port: BANK out of range");
      end
   endgenerate

   assign writer_owns = linked && (wsel == MY_SEL);
   assign reader_owns = linked && (wsel != MY_SEL);

   always_comb begin
      if (writer_owns)      ctr_cmd = wr_cmd;
      else if (reader_owns) ctr_cmd = rd_cmd;
      else                  ctr_cmd = CMD_HOLD;
   end

   assign wr_en = writer_owns;
   assign rd_en = reader_owns;
   assign we_n  = !(writer_owns && wr_req);
   assign oe_n  = !(reader_owns && rd_req);
   assign cs_n  = we_n && oe_n;

endmodule

// File: rtl/pp_buffer_ctrl.sv
module pp_buffer_ctrl
   import pp_buf_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter int GAP_CYCLES = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_clr,
   input  logic                    wr_inc,
   input  logic                    wr_dec,
   input  logic                    wr_req,
   input  logic                    rd_clr,
   input  logic                    rd_inc,
   input  logic                    rd_dec,
   input  logic                    rd_req,
   input  logic                    swap_req,
   output logic [2*ADDR_W-1:0]     bank_addr,
   output logic [1:0]              bank_cs_n,
   output logic [1:0]              bank_we_n,
   output logic [1:0]              bank_oe_n,
   output logic [1:0]              wr_xcvr_en,
   output logic [1:0]              rd_xcvr_en,
   output logic                    wr_bank
);

   ctr_cmd_e wr_cmd;
   ctr_cmd_e rd_cmd;
   logic     wsel;
   logic     linked;

   generate
      if (NBANK != 2) begin : g_bad_nbank
         $error("pp_buffer_ctrl: exactly two banks are supported");
      end
   endgenerate

   assign wr_cmd  = pick_cmd(wr_clr, wr_inc, wr_dec);
   assign rd_cmd  = pick_cmd(rd_clr, rd_inc, rd_dec);
   assign wr_bank = wsel;

   pp_swap_ctrl #(
      .GAP_CYCLES(GAP_CYCLES)
   ) swap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .swap_req (swap_req),
      .busy     (wr_req | rd_req),
      .wsel     (wsel),
      .linked   (linked)
   );

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         ctr_cmd_e bcmd;

         pp_bank_port #(
            .BANK(b)
         ) port_i (
            .wsel    (wsel),
            .linked  (linked),
            .wr_cmd  (wr_cmd),
            .rd_cmd  (rd_cmd),
            .wr_req  (wr_req),
            .rd_req  (rd_req),
            .ctr_cmd (bcmd),
            .wr_en   (wr_xcvr_en[b]),
            .rd_en   (rd_xcvr_en[b]),
            .we_n    (bank_we_n[b]),
            .oe_n    (bank_oe_n[b]),
            .cs_n    (bank_cs_n[b])
         );

         pp_addr_ctr #(
            .ADDR_W(ADDR_W)
         ) ctr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (bcmd),
            .addr  (bank_addr[b*ADDR_W +: ADDR_W])
         );
      end
   endgenerate

endmodule

// File: rtl/pp_buffer_ctrl_chk.sv
module pp_buffer_ctrl_chk #(
   parameter int ADDR_W     = 19,
   parameter int GAP_CYCLES = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_clr,
   input logic                wr_inc,
   input logic                wr_dec,
   input logic                wr_req,
   input logic                rd_clr,
   input logic                rd_inc,
   input logic                rd_dec,
   input logic                rd_req,
   input logic                swap_req,
   input logic [2*ADDR_W-1:0] bank_addr,
   input logic [1:0]          bank_cs_n,
   input logic [1:0]          bank_we_n,
   input logic [1:0]          bank_oe_n,
   input logic [1:0]          wr_xcvr_en,
   input logic [1:0]          rd_xcvr_en,
   input logic                wr_bank
);

   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   // R7
   swap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bank != $past(wr_bank)) |-> ($past(swap_req) && !$past(wr_req) && !$past(rd_req)));

   // R8
   swap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bank != $past(wr_bank)) |-> (wr_xcvr_en == 2'b00 && rd_xcvr_en == 2'b00));

   generate
      for (genvar b = 0; b < 2; b++) begin : g_chk
         // R6
         one_xcvr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_xcvr_en[b] && rd_xcvr_en[b]));

         // R9
         we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(!bank_we_n[b] && !bank_oe_n[b]));

         // R9
         we_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_we_n[b] |-> (wr_xcvr_en[b] && wr_req && !bank_cs_n[b]));

         // R1
         clr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_xcvr_en[b] && wr_clr) |=> (bank_addr[b*ADDR_W +: ADDR_W] == '0));

         // R2
         inc_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_xcvr_en[b] && wr_inc && !wr_clr) |=>
            (bank_addr[b*ADDR_W +: ADDR_W] == $past(bank_addr[b*ADDR_W +: ADDR_W]) + ONE));

         // R4
         idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_xcvr_en[b] && !rd_xcvr_en[b]) |=> $stable(bank_addr[b*ADDR_W +: ADDR_W]));
      end
   endgenerate

endmodule

bind pp_buffer_ctrl pp_buffer_ctrl_chk #(
   .ADDR_W(ADDR_W),
   .GAP_CYCLES(GAP_CYCLES)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_clr     (wr_clr),
   .wr_inc     (wr_inc),
   .wr_dec     (wr_dec),
   .wr_req     (wr_req),
   .rd_clr     (rd_clr),
   .rd_inc     (rd_inc),
   .rd_dec     (rd_dec),
   .rd_req     (rd_req),
   .swap_req   (swap_req),
   .bank_addr  (bank_addr),
   .bank_cs_n  (bank_cs_n),
   .bank_we_n  (bank_we_n),
   .bank_oe_n  (bank_oe_n),
   .wr_xcvr_en (wr_xcvr_en),
   .rd_xcvr_en (rd_xcvr_en),
   .wr_bank    (wr_bank)
);

// File: tb/pp_buffer_ctrl_tb_top.sv
module pp_buffer_ctrl_tb_top;

   localparam int AW  = 4;
   localparam int GAP = 1;
   localparam int NV  = 20;

   // Vector bits: [8]swap [7]wr_req [6]rd_req [5]wr_clr [4]wr_inc [3]wr_dec
   //              [2]rd_clr [1]rd_inc [0]rd_dec
   localparam logic [8:0] VEC [NV] = '{
      9'b0_1_0_010_000,  // writer step up with write (R1)
      9'b0_0_0_010_000,  // writer step up
      9'b0_0_1_000_010,  // reader step up with read (R4)
      9'b0_0_0_001_001,  // both step down
      9'b0_0_0_000_001,  // reader down from zero (R3)
      9'b0_0_0_011_000,  // up beats down (R2)
      9'b0_0_0_110_000,  // clear beats up (R2)
      9'b1_1_0_000_000,  // swap while writing: held off (R7)
      9'b1_0_0_000_000,  // swap taken
      9'b0_1_0_010_000,  // gap: ignored (R8)
      9'b0_1_0_010_000,  // writer now on bank 1
      9'b0_0_1_000_010,  // reader now on bank 0
      9'b0_0_0_000_101,  // clear beats down (R2)
      9'b1_0_1_000_000,  // swap while reading: held off (R7)
      9'b1_0_0_000_000,  // swap taken
      9'b0_0_1_000_010,  // gap: ignored (R8)
      9'b0_0_0_001_000,  // writer down from zero (R3)
      9'b0_0_0_001_000,  // writer down
      9'b0_1_1_000_000,  // both access
      9'b0_0_0_100_100   // both clear
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_clr = 0, wr_inc = 0, wr_dec = 0, wr_req = 0;
   logic            rd_clr = 0, rd_inc = 0, rd_dec = 0, rd_req = 0;
   logic            swap_req = 0;
   logic [2*AW-1:0] bank_addr;
   logic [1:0]      bank_cs_n, bank_we_n, bank_oe_n, wr_xcvr_en, rd_xcvr_en;
   logic            wr_bank;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [AW-1:0] m_addr [2];
   logic          m_wsel;
   int            m_gap;

   always #10 clk = ~clk;

   pp_buffer_ctrl #(.ADDR_W(AW), .GAP_CYCLES(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_clr(wr_clr), .wr_inc(wr_inc), .wr_dec(wr_dec), .wr_req(wr_req),
      .rd_clr(rd_clr), .rd_inc(rd_inc), .rd_dec(rd_dec), .rd_req(rd_req),
      .swap_req(swap_req), .bank_addr(bank_addr), .bank_cs_n(bank_cs_n),
      .bank_we_n(bank_we_n), .bank_oe_n(bank_oe_n), .wr_xcvr_en(wr_xcvr_en),
      .rd_xcvr_en(rd_xcvr_en), .wr_bank(wr_bank)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_addr[0] = '0;
      m_addr[1] = '0;
      m_wsel    = 1'b0;
      m_gap     = 0;
   endtask

   function automatic logic [AW-1:0] apply(input logic [AW-1:0] a, input logic c,
                                           input logic i, input logic d);
      if (c)      return '0;
      else if (i) return a + 1'b1;
      else if (d) return a - 1'b1;
      else        return a;
   endfunction

   task automatic check_state(input string ctx);
      logic       lk;
      logic [1:0] we, re;
      lk = (m_gap == 0);
      we = lk ? (m_wsel ? 2'b10 : 2'b01) : 2'b00;
      re = lk ? (m_wsel ? 2'b01 : 2'b10) : 2'b00;
      check({"R1 bank0 addr ", ctx}, 32'(bank_addr[AW-1:0]), 32'(m_addr[0]));
      check({"R4 bank1 addr ", ctx}, 32'(bank_addr[2*AW-1:AW]), 32'(m_addr[1]));
      check({"R5 wr_bank ", ctx}, 32'(wr_bank), 32'(m_wsel));
      check({"R6 wr_xcvr_en ", ctx}, 32'(wr_xcvr_en), 32'(we));
      check({"R8 rd_xcvr_en ", ctx}, 32'(rd_xcvr_en), 32'(re));
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input logic [8:0] v, input string ctx);
      logic       lk;
      logic [1:0] we_n, oe_n;
      {swap_req, wr_req, rd_req, wr_clr, wr_inc, wr_dec, rd_clr, rd_inc, rd_dec} = v;
      #1;
      lk = (m_gap == 0);
      we_n = 2'b11;
      oe_n = 2'b11;
      if (lk && wr_req) we_n[m_wsel]  = 1'b0;
      if (lk && rd_req) oe_n[!m_wsel] = 1'b0;
      check({"R9 we_n ", ctx}, 32'(bank_we_n), 32'(we_n));
      check({"R9 oe_n ", ctx}, 32'(bank_oe_n), 32'(oe_n));
      check({"R9 cs_n ", ctx}, 32'(bank_cs_n), 32'(we_n & oe_n));
      if (lk) begin
         m_addr[m_wsel]  = apply(m_addr[m_wsel], v[5], v[4], v[3]);
         m_addr[!m_wsel] = apply(m_addr[!m_wsel], v[2], v[1], v[0]);
         if (v[8] && !v[7] && !v[6]) begin
            m_wsel = !m_wsel;
            m_gap  = GAP;
         end
      end else begin
         m_gap--;
      end
      @(posedge clk);
      @(negedge clk);
      check_state(ctx);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R10: reset state
      check_state("reset R10");
      rst_n = 1'b1;
      @(negedge clk);
      check_state("after release R10");

      for (int k = 0; k < NV; k++) begin
         step(VEC[k], $sformatf("vec %0d", k));
      end

      // R3: sixteen step-ups from zero return to zero on the writer bank
      step(9'b0_0_0_100_000, "clear for wrap");
      for (int k = 0; k < 16; k++) begin
         step(9'b0_0_0_010_000, $sformatf("R3 wrap up %0d", k));
      end
      check("R3 full cycle back to zero", 32'(bank_addr[m_wsel*AW +: AW]), 32'd0);

      // R7: swap held off for several busy cycles, then taken
      for (int k = 0; k < 3; k++) begin
         step(9'b1_1_1_000_000, $sformatf("R7 busy swap %0d", k));
      end
      step(9'b1_0_0_000_000, "R7 idle swap");
      step(9'b0_1_1_101_101, "R8 gap ignores all");
      step(9'b0_0_0_010_010, "after gap");

      // R10: reset in the middle of operation
      step(9'b1_0_0_000_000, "swap before reset");
      rst_n = 1'b0;
      #1;
      model_reset();
      @(negedge clk);
      check_state("mid-run reset R10");
      rst_n = 1'b1;
      step(9'b0_1_0_010_000, "post reset R10");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule